// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

This block is a general-purpose I/O peripheral with sixteen lines behind a small 32-bit register bus. Software sets the value each line drives and chooses, line by line, whether the pin is driven or left as an input. It reads back the pin levels after they have been synchronized. Each line also carries an interrupt detector. A three-bit style code selects one of five conditions: high level, low level, rising edge, falling edge or any transition. When the selected condition is met, the line's pending flag sets. Software clears pending flags by writing ones.

The thirteen lowest lines each drive a dedicated active-high interrupt wire to the CPU interrupt controller. The upper three lines raise pending flags but drive no wire. A clock-control register can hand lines 14 and 15 over to an external clock-output function. When a line is handed over, the block routes that function's signal onto the pin and drives it. The same register stores the configuration bytes for the external clock generator. A debounce-select word is kept as plain storage.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge where `bus_en` and `bus_wr` are both high. Read data is a combinational function of `bus_word` and the current register state. The bus has no back-pressure, and every access completes in the cycle it is presented.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Reset state. The output-data, status, both style, clock-control and debounce registers all read 0. The direction register reads 0x0000FFFF, so every line is an input. No pin is driven and no interrupt wire is high.
- R2: Word 0 (byte offset 0x00) holds output data in bits 15:0, and word 1 (0x04) holds direction in bits 15:0. For a line not handed to the clock function, `pin_oe[n]` is the inverse of direction bit n, where 1 means input. `pin_out[n]` is output-data bit n.
- R3: Word 2 (0x08) returns the pin levels after a two-flop synchronizer. A pin change is visible on the second rising edge after it. Writes to word 2 change nothing.
- R4: Style code 0 (high level) and code 1 (low level) set the pending flag on every cycle the synchronized level matches. A clear written while the level persists therefore leaves the flag set.
- R5: Style code 2 (rising edge), code 3 (falling edge) and code 4 (any transition) set the flag when the synchronized level differs from its value one cycle earlier in the chosen direction. The flag then stays set until it is cleared.
- R6: Writing word 3 (0x0C) clears each pending flag whose data bit is 1, and leaves flags whose data bit is 0 untouched. If a set condition occurs in the same cycle as a clear, the flag stays set.
- R7: `irq_out[n]` for n in 0..12 equals pending flag n. Flags 13..15 read back in word 3 but appear on no wire.
- R8: Style codes 5, 6 and 7 never set a pending flag.
- R9: Line k (k = 0..7) takes its style from bits [3k+2:3k] of word 4 (0x10). Line 8+k takes its style from the same bits of word 5 (0x14). Bits 31:24 of both words read 0.
- R10: In word 6 (0x18), bit 8 hands pin 14 to `clk_src_a` and bit 24 hands pin 15 to `clk_src_b`. A handed-over pin is driven regardless of its direction bit. Bits 7:0 appear on `clk_cfg_a` and bits 23:16 on `clk_cfg_b`. All other bits read 0.
- R11: Word 7 (0x1C) stores and returns all 32 written bits and has no effect on pins or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Value to drive onto each pin |
| pin_oe | output | 16 | 1 = drive the pin |
| clk_src_a | input | 1 | Clock-function signal for pin 14 |
| clk_src_b | input | 1 | Clock-function signal for pin 15 |
| irq_out | output | 13 | Dedicated interrupt wires for lines 0..12 |
| clk_cfg_a | output | 8 | Stored configuration byte, clock output A |
| clk_cfg_b | output | 8 | Stored configuration byte, clock output B |

## Verification
Register writes show on read data and on the pin outputs just after the write edge, because the read path and pin mux are combinational. A pin change shows on input readback two rising edges later. It reaches the pending flags and interrupt wires on the third edge, one register more for the level-detection stage. A clear written at edge E removes a flag from edge E onward unless a set condition is evaluated at that same edge. The bench drives inputs just after each rising edge and compares every output against a behavioural model at the falling edge, so each result is sampled in the cycle these counts predict.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [2:0] REG_OUT    = 3'd0;
  localparam logic [2:0] REG_DIR    = 3'd1;
  localparam logic [2:0] REG_IN     = 3'd2;
  localparam logic [2:0] REG_STAT   = 3'd3;
  localparam logic [2:0] REG_STY_LO = 3'd4;
  localparam logic [2:0] REG_STY_HI = 3'd5;
  localparam logic [2:0] REG_CLK    = 3'd6;
  localparam logic [2:0] REG_DBS    = 3'd7;

  localparam int STY_W = 3;

  typedef enum logic [2:0] {
    STY_LVL_HI = 3'd0,
    STY_LVL_LO = 3'd1,
    STY_RISE   = 3'd2,
    STY_FALL   = 3'd3,
    STY_ANY    = 3'd4
  } sty_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] now,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] now_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  assign now  = now_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_line_det.sv
module gpio_line_det
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur,
  input  logic             last,
  input  logic [STY_W-1:0] style,
  input  logic             clr,
  output logic             flag
);
  logic hit;
  logic flag_q;

  always_comb begin
    case (style)
      STY_LVL_HI: hit = cur;
      STY_LVL_LO: hit = ~cur;
      STY_RISE:   hit = cur & ~last;
      STY_FALL:   hit = ~cur & last;
      STY_ANY:    hit = cur ^ last;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q & ~clr) | hit;
  end

  assign flag = flag_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NLINES     = 16,
  parameter int CLK_LINE_A = 14,
  parameter int CLK_LINE_B = 15
) (
  input  logic [NLINES-1:0] out_data,
  input  logic [NLINES-1:0] dir_in,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              src_a,
  input  logic              src_b,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe
);
  for (genvar i = 0; i < NLINES; i++) begin : g_pin
    if (i == CLK_LINE_A) begin : g_a
      assign pin_out[i] = sel_a ? src_a : out_data[i];
      assign pin_oe[i]  = sel_a | ~dir_in[i];
    end else if (i == CLK_LINE_B) begin : g_b
      assign pin_out[i] = sel_b ? src_b : out_data[i];
      assign pin_oe[i]  = sel_b | ~dir_in[i];
    end else begin : g_plain
      assign pin_out[i] = out_data[i];
      assign pin_oe[i]  = ~dir_in[i];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NLINES     = 16,
  parameter int NIRQ       = 13,
  parameter int CLK_LINE_A = 14,
  parameter int CLK_LINE_B = 15,
  parameter int CFG_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [2:0]        bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  input  logic              clk_src_a,
  input  logic              clk_src_b,
  output logic [NIRQ-1:0]   irq_out,
  output logic [CFG_W-1:0]  clk_cfg_a,
  output logic [CFG_W-1:0]  clk_cfg_b
);
  localparam int LPR       = NLINES / 2;
  localparam int STY_BITS  = STY_W * LPR;
  localparam int MUX_A_BIT = CFG_W;
  localparam int CFG_B_LSB = 16;
  localparam int MUX_B_BIT = CFG_B_LSB + CFG_W;

  logic                    wr_en;
  logic [NLINES-1:0]       out_q;
  logic [NLINES-1:0]       dir_q;
  logic [STY_W*NLINES-1:0] style_flat;
  logic [CFG_W-1:0]        cfg_a_q;
  logic [CFG_W-1:0]        cfg_b_q;
  logic                    mux_a;
  logic                    mux_b;
  logic [31:0]             dbs_q;
  logic [NLINES-1:0]       clr;
  logic [NLINES-1:0]       in_now;
  logic [NLINES-1:0]       in_prev;
  logic [NLINES-1:0]       stat;

  assign wr_en = bus_en & bus_wr;
  assign clr   = (wr_en && bus_word == REG_STAT) ? bus_wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q      <= '0;
      dir_q      <= '1;
      style_flat <= '0;
      cfg_a_q    <= '0;
      cfg_b_q    <= '0;
      mux_a      <= 1'b0;
      mux_b      <= 1'b0;
      dbs_q      <= '0;
    end else if (wr_en) begin
      case (bus_word)
        REG_OUT:    out_q <= bus_wdata[NLINES-1:0];
        REG_DIR:    dir_q <= bus_wdata[NLINES-1:0];
        REG_STY_LO: style_flat[STY_BITS-1:0] <= bus_wdata[STY_BITS-1:0];
        REG_STY_HI: style_flat[2*STY_BITS-1:STY_BITS] <= bus_wdata[STY_BITS-1:0];
        REG_CLK: begin
          cfg_a_q <= bus_wdata[CFG_W-1:0];
          mux_a   <= bus_wdata[MUX_A_BIT];
          cfg_b_q <= bus_wdata[CFG_B_LSB +: CFG_W];
          mux_b   <= bus_wdata[MUX_B_BIT];
        end
        REG_DBS:    dbs_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_word)
      REG_OUT:    bus_rdata[NLINES-1:0]   = out_q;
      REG_DIR:    bus_rdata[NLINES-1:0]   = dir_q;
      REG_IN:     bus_rdata[NLINES-1:0]   = in_now;
      REG_STAT:   bus_rdata[NLINES-1:0]   = stat;
      REG_STY_LO: bus_rdata[STY_BITS-1:0] = style_flat[STY_BITS-1:0];
      REG_STY_HI: bus_rdata[STY_BITS-1:0] = style_flat[2*STY_BITS-1:STY_BITS];
      REG_CLK: begin
        bus_rdata[CFG_W-1:0]          = cfg_a_q;
        bus_rdata[MUX_A_BIT]          = mux_a;
        bus_rdata[CFG_B_LSB +: CFG_W] = cfg_b_q;
        bus_rdata[MUX_B_BIT]          = mux_b;
      end
      default:    bus_rdata = dbs_q;
    endcase
  end

  gpio_sync #(.W(NLINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .now  (in_now),
    .prev (in_prev)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_det
    gpio_line_det u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .cur  (in_now[i]),
      .last (in_prev[i]),
      .style(style_flat[STY_W*i +: STY_W]),
      .clr  (clr[i]),
      .flag (stat[i])
    );
  end

  assign irq_out   = stat[NIRQ-1:0];
  assign clk_cfg_a = cfg_a_q;
  assign clk_cfg_b = cfg_b_q;

  gpio_pin_mux #(
    .NLINES    (NLINES),
    .CLK_LINE_A(CLK_LINE_A),
    .CLK_LINE_B(CLK_LINE_B)
  ) u_mux (
    .out_data(out_q),
    .dir_in  (dir_q),
    .sel_a   (mux_a),
    .sel_b   (mux_b),
    .src_a   (clk_src_a),
    .src_b   (clk_src_b),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NLINES = 16,
  parameter int NIRQ   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [2:0]        bus_word,
  input logic [NIRQ-1:0]   wdata_lo,
  input logic [NLINES-1:0] pin_in,
  input logic [NLINES-1:0] in_now,
  input logic [NIRQ-1:0]   irq_out,
  input logic [3*NIRQ-1:0] style_lo,
  input logic              mux_a,
  input logic              pin_out_a,
  input logic              pin_oe_a,
  input logic              clk_src_a,
  input logic [13:0]       pin_oe_lo
);
  logic       seen;
  logic [1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      cnt  <= 2'd0;
    end else begin
      seen <= 1'b1;
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (pin_oe_lo == 14'h0 && irq_out == '0)); // R1

  AST_INPUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= 2'd2 |-> in_now == $past(pin_in, 2)); // R3

  AST_CLK_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    mux_a |-> (pin_oe_a && pin_out_a == clk_src_a)); // R10

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    logic clr_i;
    logic [2:0] sty_i;
    assign clr_i = bus_en && bus_wr && bus_word == 3'd3 && wdata_lo[i];
    assign sty_i = style_lo[3*i +: 3];

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[i] && sty_i inside {3'd2, 3'd3, 3'd4} && !clr_i) |=> irq_out[i]); // R5

    AST_BAD_STYLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out[i] && sty_i >= 3'd5) |=> !irq_out[i]); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && sty_i >= 3'd5) |=> !irq_out[i]); // R6
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NLINES(NLINES), .NIRQ(NIRQ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_wr   (bus_wr),
  .bus_word (bus_word),
  .wdata_lo (bus_wdata[NIRQ-1:0]),
  .pin_in   (pin_in),
  .in_now   (in_now),
  .irq_out  (irq_out),
  .style_lo (style_flat[3*NIRQ-1:0]),
  .mux_a    (mux_a),
  .pin_out_a(pin_out[CLK_LINE_A]),
  .pin_oe_a (pin_oe[CLK_LINE_A]),
  .clk_src_a(clk_src_a),
  .pin_oe_lo(pin_oe[13:0])
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_word = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = 16'h0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        clk_src_a = 1'b0;
  logic        clk_src_b = 1'b0;
  logic [12:0] irq_out;
  logic [7:0]  clk_cfg_a;
  logic [7:0]  clk_cfg_b;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .clk_src_a(clk_src_a), .clk_src_b(clk_src_b), .irq_out(irq_out),
    .clk_cfg_a(clk_cfg_a), .clk_cfg_b(clk_cfg_b)
  );

  // behavioural reference model
  logic [15:0] m_out, m_dir, m_stat;
  int          m_sty[16];
  logic [7:0]  m_cfg_a, m_cfg_b;
  logic        m_mux_a, m_mux_b;
  logic [31:0] m_dbs;
  logic [15:0] hist[$];

  function automatic logic [31:0] mrd(input logic [2:0] w);
    logic [31:0] r;
    r = 32'h0;
    case (w)
      3'd0: r[15:0] = m_out;
      3'd1: r[15:0] = m_dir;
      3'd2: r[15:0] = hist[1];
      3'd3: r[15:0] = m_stat;
      3'd4: for (int k = 0; k < 8; k++) r[3*k +: 3] = m_sty[k][2:0];
      3'd5: for (int k = 0; k < 8; k++) r[3*k +: 3] = m_sty[8+k][2:0];
      3'd6: r = {7'h0, m_mux_b, m_cfg_b, 7'h0, m_mux_a, m_cfg_a};
      default: r = m_dbs;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] nw, pv, setv, clrv;
    if (!rst_n) begin
      m_out = 0; m_dir = 16'hFFFF; m_stat = 0; m_cfg_a = 0; m_cfg_b = 0;
      m_mux_a = 0; m_mux_b = 0; m_dbs = 0;
      for (int i = 0; i < 16; i++) m_sty[i] = 0;
      hist = {16'h0, 16'h0, 16'h0};
    end else begin
      nw = hist[1]; pv = hist[2]; setv = 0;
      for (int i = 0; i < 16; i++) begin
        case (m_sty[i])
          0: setv[i] = nw[i];
          1: setv[i] = !nw[i];
          2: setv[i] = nw[i] && !pv[i];
          3: setv[i] = !nw[i] && pv[i];
          4: setv[i] = nw[i] != pv[i];
          default: setv[i] = 1'b0;
        endcase
      end
      clrv = (bus_en && bus_wr && bus_word == 3'd3) ? bus_wdata[15:0] : 16'h0;
      m_stat = (m_stat & ~clrv) | setv;
      if (bus_en && bus_wr) begin
        case (bus_word)
          3'd0: m_out = bus_wdata[15:0];
          3'd1: m_dir = bus_wdata[15:0];
          3'd4: for (int k = 0; k < 8; k++) m_sty[k] = int'(bus_wdata[3*k +: 3]);
          3'd5: for (int k = 0; k < 8; k++) m_sty[8+k] = int'(bus_wdata[3*k +: 3]);
          3'd6: begin
            m_cfg_a = bus_wdata[7:0]; m_mux_a = bus_wdata[8];
            m_cfg_b = bus_wdata[23:16]; m_mux_b = bus_wdata[24];
          end
          3'd7: m_dbs = bus_wdata;
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] e_out, e_oe;
    if (rst_n && !done) begin
      e_out = m_out; e_oe = ~m_dir;
      if (m_mux_a) begin e_out[14] = clk_src_a; e_oe[14] = 1'b1; end
      if (m_mux_b) begin e_out[15] = clk_src_b; e_oe[15] = 1'b1; end
      chk("R2 pin_out", {16'h0, pin_out}, {16'h0, e_out});
      chk("R2 pin_oe", {16'h0, pin_oe}, {16'h0, e_oe});
      chk("R7 irq_out", {19'h0, irq_out}, {19'h0, m_stat[12:0]});
      chk("R10 clk_cfg", {16'h0, clk_cfg_b, clk_cfg_a}, {16'h0, m_cfg_b, m_cfg_a});
      if (bus_en && !bus_wr) chk(cur_req, bus_rdata, mrd(bus_word));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bwrite(input logic [2:0] w, input logic [31:0] d);
    bus_en = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [2:0] w, input logic [31:0] exp, input string req);
    bus_en = 1; bus_wr = 0; bus_word = w;
    @(negedge clk);
    chk(req, bus_rdata, exp);
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo_val;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset values
    cur_req = "R1";
    chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 irq_out", {19'h0, irq_out}, 32'h0);
    for (int w = 0; w < 8; w++)
      bread(3'(w), (w == 1) ? 32'h0000FFFF : 32'h0, "R1 readback");

    // R2 output drive
    cur_req = "R2";
    bwrite(3'd0, 32'h0000A5C3);
    bwrite(3'd1, 32'h000000FF);
    chk("R2 pin_oe value", {16'h0, pin_oe}, 32'h0000FF00);
    chk("R2 pin_out value", {16'h0, pin_out}, 32'h0000A5C3);

    // R3 synchronized readback, writes ignored
    cur_req = "R3";
    pin_in = 16'h1234;
    idle(1);
    bread(3'd2, 32'h0, "R3 not yet visible");
    idle(1);
    bread(3'd2, 32'h00001234, "R3 readback");
    bwrite(3'd2, 32'h0000FFFF);
    bread(3'd2, 32'h00001234, "R3 write ignored");
    pin_in = 16'h0;
    idle(3);
    bwrite(3'd3, 32'hFFFF);
    bread(3'd3, 32'h0, "R6 clear all");

    // R4 level high on line 0
    cur_req = "R4";
    pin_in = 16'h0001;
    idle(3);
    bread(3'd3, 32'h1, "R4 level high set");
    bwrite(3'd3, 32'h1);
    bread(3'd3, 32'h1, "R4 reasserts after clear");
    pin_in = 16'h0;
    idle(3);
    bwrite(3'd3, 32'h1);
    bread(3'd3, 32'h0, "R4 cleared after level drops");
    // R4 level low on line 1
    bwrite(3'd4, 32'h8);
    idle(1);
    bread(3'd3, 32'h2, "R4 level low set");
    pin_in = 16'h0002;
    idle(3);
    bwrite(3'd3, 32'hFFFF);
    bread(3'd3, 32'h0, "R4 level low cleared");

    // R9 style packing, lines 0..7: codes 0,1,2,3,4,6,5,7
    cur_req = "R9";
    lo_val = (1 << 3) | (2 << 6) | (3 << 9) | (4 << 12) | (6 << 15) | (5 << 18) | (7 << 21);
    bwrite(3'd4, lo_val | 32'hFF000000);
    bread(3'd4, lo_val, "R9 low style readback");

    // R5 edges
    cur_req = "R5";
    pin_in = 16'h0006; idle(3);
    bread(3'd3, 32'h4, "R5 rising sets");
    pin_in = 16'h0002; idle(3);
    bread(3'd3, 32'h4, "R5 rising ignores fall");
    pin_in = 16'h000A; idle(3);
    bread(3'd3, 32'h4, "R5 falling ignores rise");
    pin_in = 16'h0002; idle(3);
    bread(3'd3, 32'hC, "R5 falling sets");
    pin_in = 16'h0012; idle(3);
    bread(3'd3, 32'h1C, "R5 any transition sets");
    idle(4);
    bread(3'd3, 32'h1C, "R5 edge flags held");

    // R6 write-one-to-clear
    cur_req = "R6";
    bwrite(3'd3, 32'h0);
    bread(3'd3, 32'h1C, "R6 zero write no effect");
    bwrite(3'd3, 32'hC);
    bread(3'd3, 32'h10, "R6 selected bits cleared");

    // R8 codes 5..7 quiet (lines 5,6,7)
    cur_req = "R8";
    pin_in = 16'h00F2; idle(3);
    pin_in = 16'h0012; idle(3);
    bread(3'd3, 32'h10, "R8 reserved codes never set");

    // R7 line 13 has no wire
    cur_req = "R7";
    bwrite(3'd5, 32'h2 << 15);
    pin_in = 16'h2012; idle(3);
    bread(3'd3, 32'h2010, "R7 line 13 status set");
    chk("R7 no wire for line 13", {19'h0, irq_out}, 32'h10);
    pin_in = 16'h0012; idle(3);

    // R9 high register
    cur_req = "R9";
    bwrite(3'd5, 32'hFFFFFFFF);
    bread(3'd5, 32'h00FFFFFF, "R9 unused bits read zero");
    bwrite(3'd5, 32'h4 << 21);
    bwrite(3'd3, 32'hFFFF);
    bread(3'd3, 32'h0, "R9 all clear");
    pin_in = 16'h8012; idle(3);
    bread(3'd3, 32'h8000, "R9 line 15 field position");
    pin_in = 16'h0012; idle(3);

    // R6 set wins against clear, swept over offsets
    cur_req = "R6";
    pin_in = 16'h0002; idle(3);
    bwrite(3'd3, 32'hFFFF);
    for (int d = 0; d < 5; d++) begin
      pin_in = 16'h0006;
      idle(d);
      bwrite(3'd3, 32'h4);
      if (d == 2) bread(3'd3, 32'h4, "R6 set wins over clear");
      pin_in = 16'h0002;
      idle(3);
      bwrite(3'd3, 32'hFFFF);
    end

    // R10 clock handover
    cur_req = "R10";
    bwrite(3'd1, 32'hFFFF);
    bwrite(3'd6, 32'h015501AB);
    bread(3'd6, 32'h015501AB, "R10 readback");
    chk("R10 cfg a", {24'h0, clk_cfg_a}, 32'hAB);
    chk("R10 cfg b", {24'h0, clk_cfg_b}, 32'h55);
    clk_src_a = 1; clk_src_b = 0;
    #1;
    chk("R10 pin 14 carries clock", {30'h0, pin_oe[14], pin_out[14]}, 32'h3);
    chk("R10 pin 15 carries clock", {30'h0, pin_oe[15], pin_out[15]}, 32'h2);
    for (int t = 0; t < 6; t++) begin
      clk_src_a = ~clk_src_a; clk_src_b = ~clk_src_b;
      idle(1);
    end
    bwrite(3'd6, 32'hFFFFFFFF);
    bread(3'd6, 32'h01FF01FF, "R10 unused bits read zero");
    bwrite(3'd6, 32'h0);
    chk("R10 released pins", {16'h0, pin_oe}, 32'h0);

    // R11 debounce storage
    cur_req = "R11";
    bwrite(3'd7, 32'hDEADBEEF);
    bread(3'd7, 32'hDEADBEEF, "R11 storage");
    bread(3'd3, 32'h0, "R11 no flag effect");

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule